// File: doc/BRIEF.md
# DES / Triple-DES Accelerator Register Front-End

This block is the software-facing shell of a 64-bit-block DES / triple-DES engine. A processor reaches it through a simple 32-bit register bus. Each bus access is a single cycle with a byte address. Writes take effect at the clock edge, and reads return data in the same cycle.

The block holds the following state:
- six key words, which the core sees as one 192-bit vector;
- the two-word chaining (IV) register;
- the mode controls;
- a running byte count.

The front-end collects a two-word input block and starts the external cipher core with a one-cycle pulse. It then holds the core's result until software has read it. The cipher rounds and key schedule live in that core and are not part of this block.

Software can move data in two ways:
- **Programmed I/O.** The block raises a "ready for input" event and a "result available" event in turn. Either event can drive the interrupt line.
- **DMA.** Two request lines follow the same two conditions, each gated by its own enable bit.

The byte count drops by 8 for every block consumed, and the transfer is over when it reaches zero. In chaining mode the block keeps the IV register at the latest chaining value, so software can read it back when the transfer finishes.

Top module: `cipher_regfront`

## Requirements
- R1: Key word k (k = 0..5) is written at byte address 0x14 - 4*(k XOR 1): k0 at 0x10, k1 at 0x14, k2 at 0x08, k3 at 0x0C, k4 at 0x00, k5 at 0x04. It drives `core_key[32k+31:32k]`. Key addresses read as zero.
- R2: The control register is at 0x20.
  - Bit 4 (chaining mode), bit 3 (triple-DES) and bit 2 (1 = encrypt) are read/write and drive `core_cbc`, `core_tdes` and `core_encrypt`.
  - Bit 1 reads input-ready and bit 0 reads output-ready. Writes to bits 1:0 have no effect.
- R3: The IV words are at 0x18 (bits 31:0) and 0x1C (bits 63:32), and they are readable.
  - In chaining mode, when a block completes, the IV takes the core result if encrypting, or the input block if decrypting.
  - With chaining off, the IV does not change.
- R4: Data words are at 0x28 (bits 31:0) and 0x2C (bits 63:32). A write to 0x2C while input-ready is set does two things:
  - it pulses `core_start` for exactly one cycle, in the next cycle, with `core_din` = {word 0x2C, word 0x28};
  - it clears input-ready.
- R5: Data writes made while input-ready is clear are ignored: no start pulse, and the held input block is unchanged.
- R6: Output-ready behaves as follows:
  - It is set at the edge where `core_done` is seen while a block is in flight.
  - While it is set, 0x28 and 0x2C read the result's low and high words.
  - A read of 0x2C clears it and lowers the byte count (at 0x24) by 8.
- R7: Input-ready is set only when all three hold: the byte count is nonzero, no block is in flight, and no result is waiting. At a count of zero the transfer is over and input-ready stays clear.
- R8: The status register is at 0x3C and the enable register at 0x40.
  - Bit 1 is the input event and bit 2 is the output event.
  - A status bit is set when its condition rises, and it is cleared by writing 0 to it. Writing 1 leaves it unchanged.
  - `irq` is high whenever some status bit and its enable are both set.
- R9: The DMA mask register is at 0x34. Bit 5 gates `dma_in_req` with input-ready, and bit 6 gates `dma_out_req` with output-ready. Other bits read as zero.
- R10: Fixed and reset values:
  - 0x30 reads the revision, with the major number in bits 10:8 and the minor number in bits 5:0.
  - Unmapped addresses read as zero.
  - After reset, every register, `irq` and both DMA requests are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (same cycle) |
| core_start | output | 1 | One-cycle start pulse to the cipher core |
| core_din | output | 64 | Input block for the core |
| core_key | output | 192 | Six key words, word k at bits 32k+31:32k |
| core_iv | output | 64 | Chaining value |
| core_cbc | output | 1 | Chaining mode |
| core_tdes | output | 1 | Triple-DES mode |
| core_encrypt | output | 1 | 1 = encrypt |
| core_done | input | 1 | Core result valid pulse |
| core_dout | input | 64 | Core result block |
| irq | output | 1 | Interrupt request |
| dma_in_req | output | 1 | DMA request for an input block |
| dma_out_req | output | 1 | DMA request for a result block |

## Verification
The timing of each result, counted from the clock edge of its bus access:
- **Same cycle:** read data.
- **Next cycle:** register writes become visible, `core_start` appears for one cycle, and input-ready drops.
- **One edge after a rising condition:** the status bit sets. The bench therefore always waits at least one full clock after an event before reading status or `irq`.
- **Four cycles after the start pulse:** the stand-in core returns its result. The bench polls output-ready with a bounded loop rather than assuming a fixed cycle.

The bench samples every output half a clock after the edge that caused it.

// File: rtl/cipher_regfront.sv
module cipher_regfront #(
  parameter int          AW        = 8,
  parameter int          LEN_W     = 32,
  parameter logic [2:0]  REV_MAJOR = 3'd2,
  parameter logic [5:0]  REV_MINOR = 6'd5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          core_start,
  output logic [63:0]   core_din,
  output logic [191:0]  core_key,
  output logic [63:0]   core_iv,
  output logic          core_cbc,
  output logic          core_tdes,
  output logic          core_encrypt,
  input  logic          core_done,
  input  logic [63:0]   core_dout,
  output logic          irq,
  output logic          dma_in_req,
  output logic          dma_out_req
);
  localparam int NKEY = 6;
  localparam logic [AW-1:0] A_IVLO = AW'(8'h18);
  localparam logic [AW-1:0] A_IVHI = AW'(8'h1C);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h20);
  localparam logic [AW-1:0] A_LEN  = AW'(8'h24);
  localparam logic [AW-1:0] A_DLO  = AW'(8'h28);
  localparam logic [AW-1:0] A_DHI  = AW'(8'h2C);
  localparam logic [AW-1:0] A_REV  = AW'(8'h30);
  localparam logic [AW-1:0] A_DMA  = AW'(8'h34);
  localparam logic [AW-1:0] A_STAT = AW'(8'h3C);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h40);
  localparam logic [LEN_W-1:0] BLK = LEN_W'(8);

  function automatic logic [AW-1:0] key_addr(input int k);
    return AW'(20 - 4 * (k ^ 1));
  endfunction

  logic [31:0]      key_q [NKEY];
  logic [63:0]      iv_q, din_q, dout_q;
  logic [LEN_W-1:0] len_q;
  logic             busy_q, outv_q, inrdy_q;
  logic             st_in_q, st_out_q, en_in_q, en_out_q, dma_in_en_q, dma_out_en_q;

  wire wr     = bus_en && bus_we;
  wire rd_hi  = bus_en && !bus_we && bus_addr == A_DHI;
  wire in_rdy = (len_q != '0) && !busy_q && !outv_q;
  wire go     = wr && bus_addr == A_DHI && in_rdy;
  wire fin    = core_done && busy_q;

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) key_q[k] <= '0;
      else if (wr && bus_addr == key_addr(k)) key_q[k] <= bus_wdata;
    assign core_key[32*k +: 32] = key_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q <= '0; din_q <= '0; dout_q <= '0; len_q <= '0;
      busy_q <= 1'b0; outv_q <= 1'b0; inrdy_q <= 1'b0; core_start <= 1'b0;
      core_cbc <= 1'b0; core_tdes <= 1'b0; core_encrypt <= 1'b0;
      st_in_q <= 1'b0; st_out_q <= 1'b0; en_in_q <= 1'b0; en_out_q <= 1'b0;
      dma_in_en_q <= 1'b0; dma_out_en_q <= 1'b0;
    end else begin
      core_start <= go;
      inrdy_q    <= in_rdy;
      if (wr) begin
        case (bus_addr)
          A_CTRL: {core_cbc, core_tdes, core_encrypt} <= bus_wdata[4:2];
          A_IVLO: iv_q[31:0]  <= bus_wdata;
          A_IVHI: iv_q[63:32] <= bus_wdata;
          A_LEN:  len_q <= bus_wdata[LEN_W-1:0];
          A_DMA:  {dma_out_en_q, dma_in_en_q} <= bus_wdata[6:5];
          A_IEN:  {en_out_q, en_in_q} <= bus_wdata[2:1];
          A_DLO:  if (in_rdy) din_q[31:0] <= bus_wdata;
          A_DHI:  if (in_rdy) din_q[63:32] <= bus_wdata;
          default: ;
        endcase
      end
      if (go) busy_q <= 1'b1;
      if (fin) begin
        busy_q <= 1'b0;
        outv_q <= 1'b1;
        dout_q <= core_dout;
        if (core_cbc) iv_q <= core_encrypt ? core_dout : din_q;
      end
      if (rd_hi && outv_q) begin
        outv_q <= 1'b0;
        len_q  <= (len_q >= BLK) ? len_q - BLK : '0;
      end
      st_in_q  <= ((wr && bus_addr == A_STAT) ? st_in_q & bus_wdata[1] : st_in_q) | (in_rdy && !inrdy_q);
      st_out_q <= ((wr && bus_addr == A_STAT) ? st_out_q & bus_wdata[2] : st_out_q) | fin;
    end
  end

  assign core_din    = din_q;
  assign core_iv     = iv_q;
  assign irq         = (st_in_q && en_in_q) || (st_out_q && en_out_q);
  assign dma_in_req  = dma_in_en_q && in_rdy;
  assign dma_out_req = dma_out_en_q && outv_q;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {27'd0, core_cbc, core_tdes, core_encrypt, in_rdy, outv_q};
      A_IVLO:  bus_rdata = iv_q[31:0];
      A_IVHI:  bus_rdata = iv_q[63:32];
      A_LEN:   bus_rdata = 32'(len_q);
      A_DLO:   bus_rdata = outv_q ? dout_q[31:0] : 32'd0;
      A_DHI:   bus_rdata = outv_q ? dout_q[63:32] : 32'd0;
      A_REV:   bus_rdata = {21'd0, REV_MAJOR, 2'b00, REV_MINOR};
      A_DMA:   bus_rdata = {25'd0, dma_out_en_q, dma_in_en_q, 5'd0};
      A_STAT:  bus_rdata = {29'd0, st_out_q, st_in_q, 1'b0};
      A_IEN:   bus_rdata = {29'd0, en_out_q, en_in_q, 1'b0};
      default: bus_rdata = 32'd0;
    endcase
  end

  assert_start_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start) else $error("start pulse longer than one cycle");
  assert_no_start_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr && bus_addr == A_DHI) |=> !core_start) else $error("start while busy");
  assert_len_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && outv_q && len_q >= BLK) |=> (len_q == $past(len_q) - BLK)) else $error("length step");
  assert_ecb_iv_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_cbc && !(wr && (bus_addr == A_IVLO || bus_addr == A_IVHI))) |=> $stable(iv_q)) else $error("iv moved");
  assert_in_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdy && !inrdy_q) |=> st_in_q) else $error("input event lost");
  assert_result_sets_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (outv_q && st_out_q)) else $error("result not flagged");
endmodule

// File: tb/cipher_regfront_tb.sv
module cipher_regfront_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic core_start, core_cbc, core_tdes, core_encrypt, irq, dma_in_req, dma_out_req;
  logic [63:0] core_din, core_iv;
  logic [191:0] core_key;
  logic core_done = 1'b0;
  logic [63:0] core_dout = '0;
  int n_tests = 0, n_fail = 0, n_starts = 0, cnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cipher_regfront dut_i (.*);

  function automatic logic [63:0] xf(input logic [63:0] d, input logic [63:0] k, input logic enc);
    return {d[31:0], d[63:32]} ^ k ^ (enc ? 64'd0 : 64'hFFFF_FFFF_FFFF_FFFF);
  endfunction

  always @(posedge clk) begin
    core_done <= 1'b0;
    if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        core_done <= 1'b1;
        core_dout <= xf(core_din, core_key[63:0], core_encrypt);
      end
    end
    if (core_start) begin
      cnt <= 4;
      n_starts++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic wait_out(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 50 && !ok; i++) begin rd(8'h20, v); ok = v[0]; end
  endtask

  task automatic run_transfer(input logic [4:0] mode, input int nblk);
    logic [31:0] v, w0, w1, lo, hi;
    logic [63:0] exp, ivb;
    bit ok;
    int s0;
    wr(8'h20, {27'd0, mode});
    wr(8'h18, 32'h1111_2222); wr(8'h1C, 32'h3333_4444);
    wr(8'h24, 32'(8 * nblk));
    @(negedge clk);
    rd(8'h20, v); check(v[1] == 1, "R7 input-ready after length", {63'd0, v[1]}, 64'd1);
    rd(8'h3C, v); check(v[1] == 1 && irq, "R8 input event and irq", {v[2:1], irq}, 3'b011);
    wr(8'h3C, 32'h0);
    rd(8'h3C, v); check(v[2:1] == 0 && !irq, "R8 write-zero clears", {v[2:1], irq}, 0);
    for (int b = 0; b < nblk; b++) begin
      w0 = $urandom; w1 = $urandom;
      exp = xf({w1, w0}, core_key[63:0], mode[2]);
      ivb = core_iv;
      s0 = n_starts;
      wr(8'h28, w0); wr(8'h2C, w1);
      check(core_din == {w1, w0}, "R4 core input block", core_din, {w1, w0});
      rd(8'h20, v); check(v[1] == 0, "R4 input-ready clears", {63'd0, v[1]}, 0);
      wr(8'h2C, ~w1);
      wait_out(ok);
      check(ok, "R6 output-ready set", {63'd0, ok}, 1);
      check(n_starts == s0 + 1, "R5 one start per block", 64'(n_starts), 64'(s0 + 1));
      rd(8'h3C, v); check(v[2] == 1 && irq, "R8 output event irq", {v[2], irq}, 2'b11);
      wr(8'h3C, 32'h2);
      rd(8'h28, lo); rd(8'h2C, hi);
      check({hi, lo} == exp, "R6 result words", {hi, lo}, exp);
      rd(8'h24, v); check(v == 32'(8 * (nblk - b - 1)), "R6 length step", 64'(v), 64'(8 * (nblk - b - 1)));
      rd(8'h18, lo); rd(8'h1C, hi);
      if (!mode[4]) check({hi, lo} == ivb, "R3 iv held without chaining", {hi, lo}, ivb);
      else if (mode[2]) check({hi, lo} == exp, "R3 iv after encrypt", {hi, lo}, exp);
      else check({hi, lo} == {w1, w0}, "R3 iv after decrypt", {hi, lo}, {w1, w0});
      wr(8'h3C, 32'h0);
    end
    rd(8'h20, v); check(v[1:0] == 0, "R7 transfer over at zero", 64'(v[1:0]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] kw [6];
    int s0;
    bit ok;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h20, v); check(v == 0, "R10 control reset", 64'(v), 0);
    rd(8'h3C, v); check(v == 0 && !irq && !dma_in_req && !dma_out_req, "R10 status reset", 64'(v), 0);
    rd(8'h30, v); check(v == 32'h0000_0205, "R10 revision", 64'(v), 64'h205);
    rd(8'h44, v); check(v == 0, "R10 unmapped reads zero", 64'(v), 0);

    for (int k = 0; k < 6; k++) begin kw[k] = $urandom; wr(8'(20 - 4 * (k ^ 1)), kw[k]); end
    for (int k = 0; k < 6; k++)
      check(core_key[32*k +: 32] == kw[k], "R1 key word placement", 64'(core_key[32*k +: 32]), 64'(kw[k]));
    rd(8'h10, v); check(v == 0, "R1 key reads zero", 64'(v), 0);

    wr(8'h20, 32'h1F);
    rd(8'h20, v); check(v == 32'h1C, "R2 control bits", 64'(v), 64'h1C);
    check(core_cbc && core_tdes && core_encrypt, "R2 mode outputs", {core_cbc, core_tdes, core_encrypt}, 3'b111);

    s0 = n_starts;
    wr(8'h28, 32'hAAAA_0000); wr(8'h2C, 32'hBBBB_0000);
    repeat (8) @(negedge clk);
    rd(8'h20, v);
    check(n_starts == s0 && v[0] == 0 && core_din == 0, "R5 data ignored when not ready", core_din, 0);

    wr(8'h40, 32'h6);
    run_transfer(5'b00100, 3);
    run_transfer(5'b10100, 2 + ($urandom % 3));
    run_transfer(5'b10000, 3);
    run_transfer(5'b11000, 2);

    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, v); check(v == 32'h60, "R9 mask readback", 64'(v), 64'h60);
    wr(8'h34, 32'h20);
    wr(8'h24, 32'd8);
    @(negedge clk);
    check(dma_in_req == 1, "R9 input request", {63'd0, dma_in_req}, 1);
    wr(8'h28, 32'h1); wr(8'h2C, 32'h2);
    check(dma_in_req == 0, "R9 input request drops", {63'd0, dma_in_req}, 0);
    wait_out(ok);
    check(dma_out_req == 0, "R9 output request masked", {63'd0, dma_out_req}, 0);
    wr(8'h34, 32'h40);
    check(dma_out_req == 1, "R9 output request", {63'd0, dma_out_req}, 1);
    rd(8'h2C, v);
    check(dma_out_req == 0, "R9 output request drops", {63'd0, dma_out_req}, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule